// File: doc/BRIEF.md
# Flash self-programming command controller

This block holds the control and status register through which software drives on-chip flash self-programming. Software arms a command by writing an enable bit together with at most one command bit. The arming opens a short window. A store-instruction strobe that lands inside the window executes the armed command, using the Z-pointer address and a 16-bit data word. The command can be a temporary page-buffer fill, a page erase, a page write, a lock-bit write or a read-while-write section re-enable.

Erase and write go to a flash back end as level requests, and the back end answers with a one-cycle done pulse. While one of them runs, the block raises a busy flag for the read-while-write section or a CPU halt request for the other section. The boundary between the two sections is a page-number parameter. A load-instruction strobe inside the lock-command window returns the lock byte or the fuse byte. An interrupt request signals that the controller is idle.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, csr_rdata is 0. No request, halt, busy, interrupt, buffer write or discard is active, and lock_bits is 0.
- R2: csr_rdata layout: bit 7 is interrupt enable, bit 6 is busy, bit 5 reads 0, and bits 4:0 are the command field. Bit 0 of that field is the enable bit, bit 1 is erase, bit 2 is page write, bit 3 is lock set and bit 4 is re-enable. A write changes the command field only when bits 4:0 equal 00001, 00011, 00101, 01001 or 10001. Any other value leaves the field unchanged, although bit 7 is still written.
- R3: A legal write opens a window covering the next four cycles. A store strobe in any of those cycles executes the command. If no store arrives, the command field reads 0 from the fifth cycle after the write.
- R4: A store under the fill command (00001) asserts buf_we in the same cycle, with buf_waddr = Z[6:1] and buf_wdata = the data word. The command field is 0 in the next cycle.
- R5: A store under erase (00011) or page write (00101) raises the matching request from the next cycle, with fl_page = Z[15:7]. The request and the command field stay set until the cycle after fl_done, and then both clear.
- R6: An operation on a page below NRWW_FIRST_PAGE (default 96) sets the busy flag. An operation on a page at or above it holds cpu_halt for as long as the request is active.
- R7: The busy flag clears after a re-enable store (10001) or after a fill store.
- R8: A register write while an erase or write is active leaves the command field unchanged.
- R9: Writing 10001 while the buffer holds filled data pulses buf_discard in that cycle and marks the buffer empty. With an empty buffer there is no pulse. A completed page write also empties the buffer.
- R10: A store under the lock command (01001) sets lock_bits to the low data byte. The high byte and Z are ignored.
- R11: A load strobe in the first three cycles after arming 01001 asserts ld_hit. ld_data then carries lock_bits when ld_z0 = 0 and fuse_bits when ld_z0 = 1. A load strobe in the fourth cycle gives no hit and ld_data = 0.
- R12: irq equals interrupt-enable AND gie AND NOT the enable bit.
- R13: A store strobe outside an open window has no effect. There is no buffer write, and no change to the command field or lock_bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read value |
| gie | input | 1 | Global interrupt flag |
| st_strobe | input | 1 | Store-instruction strobe |
| st_z | input | ZW | Z-pointer for the store |
| st_data | input | 16 | Store data word |
| ld_strobe | input | 1 | Load-instruction strobe |
| ld_z0 | input | 1 | Z bit 0 for the load: 0 selects lock, 1 selects fuse |
| fuse_bits | input | BYTE_W | Fuse byte from storage |
| ld_hit | output | 1 | Special load served |
| ld_data | output | BYTE_W | Special load data |
| buf_we | output | 1 | Page-buffer write |
| buf_waddr | output | PAGE_WORD_BITS | Page-buffer word address |
| buf_wdata | output | 16 | Page-buffer word |
| buf_discard | output | 1 | Partial buffer load aborted |
| fl_erase_req | output | 1 | Page erase request |
| fl_write_req | output | 1 | Page write request |
| fl_page | output | ZW-1-PAGE_WORD_BITS | Target page number |
| fl_done | input | 1 | Back-end completion pulse |
| rww_busy | output | 1 | Read-while-write section busy |
| cpu_halt | output | 1 | CPU halt request |
| irq | output | 1 | Ready interrupt request |
| lock_bits | output | BYTE_W | Programmed lock byte |

## Verification
The bench probes both edges of the arming window. It places a store in the fourth cycle after arming and another in the fifth, and a load in the third and fourth cycles. A window one cycle short or long shows up as a missing or extra buffer write or load hit. Busy release is exercised by both paths: a re-enable after an erase and a fill after a write. A design that releases busy on only one path keeps the flag high. Register writes during an active operation and re-enables with an empty buffer are also tried. A controller that accepts writes mid-operation would lose its request, and a careless discard would pulse when there is nothing to drop.

// File: rtl/flash_spm_pkg.sv
package flash_spm_pkg;
  typedef logic [4:0] cmd_t;

  localparam cmd_t CMD_FILL  = 5'b00001;
  localparam cmd_t CMD_ERASE = 5'b00011;
  localparam cmd_t CMD_WRITE = 5'b00101;
  localparam cmd_t CMD_LOCK  = 5'b01001;
  localparam cmd_t CMD_REEN  = 5'b10001;

  function automatic logic cmd_legal(cmd_t c);
    return (c == CMD_FILL) || (c == CMD_ERASE) || (c == CMD_WRITE) ||
           (c == CMD_LOCK) || (c == CMD_REEN);
  endfunction
endpackage

// File: rtl/spm_arm_window.sv
module spm_arm_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic consume,
  output logic open_o,
  output logic early_o,
  output logic expire_o
);
  localparam int CW    = $clog2(WIN + 1);
  localparam int EARLY = (WIN > 2) ? WIN - 2 : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (arm)                cnt_d = CW'(WIN);
    else if (consume)       cnt_d = '0;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign open_o   = (cnt_q != '0);
  assign early_o  = (cnt_q >= CW'(EARLY));
  assign expire_o = (cnt_q == CW'(1)) && !arm && !consume;
endmodule

// File: rtl/spm_op_tracker.sv
module spm_op_tracker #(
  parameter int PB              = 9,
  parameter int NRWW_FIRST_PAGE = 96
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_erase,
  input  logic          start_write,
  input  logic [PB-1:0] page_in,
  input  logic          done,
  input  logic          fill_run,
  input  logic          reen_run,
  output logic          active_o,
  output logic          is_write_o,
  output logic [PB-1:0] page_o,
  output logic          busy_o,
  output logic          halt_o
);
  localparam logic [PB-1:0] BOUND = PB'(NRWW_FIRST_PAGE);

  logic          act_q, act_d, wr_q, wr_d, busy_q, busy_d;
  logic [PB-1:0] page_q, page_d;
  logic          start;

  assign start = start_erase | start_write;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    page_d = page_q;
    busy_d = busy_q;
    if (start) begin
      act_d  = 1'b1;
      wr_d   = start_write;
      page_d = page_in;
    end else if (act_q && done) begin
      act_d = 1'b0;
    end
    if (start && (page_in < BOUND)) busy_d = 1'b1;
    else if (fill_run || reen_run)  busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      page_q <= '0;
      busy_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      page_q <= page_d;
      busy_q <= busy_d;
    end
  end

  assign active_o   = act_q;
  assign is_write_o = wr_q;
  assign page_o     = page_q;
  assign busy_o     = busy_q;
  assign halt_o     = act_q && (page_q >= BOUND);
endmodule

// File: rtl/spm_lock_store.sv
module spm_lock_store #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_we,
  input  logic [BYTE_W-1:0] lock_wdata,
  input  logic [BYTE_W-1:0] fuse_in,
  input  logic              sel_fuse,
  output logic [BYTE_W-1:0] lock_o,
  output logic [BYTE_W-1:0] rd_o
);
  logic [BYTE_W-1:0] lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (lock_we) lock_d = lock_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= '0;
    else        lock_q <= lock_d;
  end

  assign lock_o = lock_q;
  assign rd_o   = sel_fuse ? fuse_in : lock_q;
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import flash_spm_pkg::*;
#(
  parameter int ZW              = 16,
  parameter int PAGE_WORD_BITS  = 6,
  parameter int NRWW_FIRST_PAGE = 96,
  parameter int ARM_WINDOW      = 4,
  parameter int BYTE_W          = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         csr_we,
  input  logic [7:0]                   csr_wdata,
  output logic [7:0]                   csr_rdata,
  input  logic                         gie,
  input  logic                         st_strobe,
  input  logic [ZW-1:0]                st_z,
  input  logic [15:0]                  st_data,
  input  logic                         ld_strobe,
  input  logic                         ld_z0,
  input  logic [BYTE_W-1:0]            fuse_bits,
  output logic                         ld_hit,
  output logic [BYTE_W-1:0]            ld_data,
  output logic                         buf_we,
  output logic [PAGE_WORD_BITS-1:0]    buf_waddr,
  output logic [15:0]                  buf_wdata,
  output logic                         buf_discard,
  output logic                         fl_erase_req,
  output logic                         fl_write_req,
  output logic [ZW-2-PAGE_WORD_BITS:0] fl_page,
  input  logic                         fl_done,
  output logic                         rww_busy,
  output logic                         cpu_halt,
  output logic                         irq,
  output logic [BYTE_W-1:0]            lock_bits
);
  localparam int PB = ZW - 1 - PAGE_WORD_BITS;
  localparam int WB = PAGE_WORD_BITS;

  cmd_t cmd_q, cmd_d;
  logic ie_q, ie_d, bufv_q, bufv_d;

  logic win_open, win_early, win_expire;
  logic op_active, op_is_write, op_busy, op_halt;
  logic [PB-1:0] op_page;
  logic [BYTE_W-1:0] lock_rd;

  logic armed, st_go, csr_ok, op_done;
  logic go_fill, go_erase, go_write, go_lock, go_reen;

  assign armed    = cmd_q[0] && win_open && !op_active;
  assign st_go    = st_strobe && armed;
  assign csr_ok   = csr_we && cmd_legal(csr_wdata[4:0]) && !op_active && !st_go;
  assign op_done  = op_active && fl_done;
  assign go_fill  = st_go && (cmd_q == CMD_FILL);
  assign go_erase = st_go && (cmd_q == CMD_ERASE);
  assign go_write = st_go && (cmd_q == CMD_WRITE);
  assign go_lock  = st_go && (cmd_q == CMD_LOCK);
  assign go_reen  = st_go && (cmd_q == CMD_REEN);

  spm_arm_window #(.WIN(ARM_WINDOW)) u_win (
    .clk(clk), .rst_n(rst_n), .arm(csr_ok), .consume(st_go),
    .open_o(win_open), .early_o(win_early), .expire_o(win_expire)
  );

  spm_op_tracker #(.PB(PB), .NRWW_FIRST_PAGE(NRWW_FIRST_PAGE)) u_op (
    .clk(clk), .rst_n(rst_n), .start_erase(go_erase), .start_write(go_write),
    .page_in(st_z[ZW-1:WB+1]), .done(fl_done), .fill_run(go_fill),
    .reen_run(go_reen), .active_o(op_active), .is_write_o(op_is_write),
    .page_o(op_page), .busy_o(op_busy), .halt_o(op_halt)
  );

  spm_lock_store #(.BYTE_W(BYTE_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_we(go_lock),
    .lock_wdata(st_data[BYTE_W-1:0]), .fuse_in(fuse_bits), .sel_fuse(ld_z0),
    .lock_o(lock_bits), .rd_o(lock_rd)
  );

  // Command, interrupt-enable and buffer-state next values
  always_comb begin
    cmd_d  = cmd_q;
    ie_d   = ie_q;
    bufv_d = bufv_q;
    if (csr_we) ie_d = csr_wdata[7];
    if (op_done)                             cmd_d = '0;
    else if (csr_ok)                         cmd_d = csr_wdata[4:0];
    else if (st_go && !go_erase && !go_write) cmd_d = '0;
    else if (win_expire && !op_active)       cmd_d = '0;
    if (go_fill)                             bufv_d = 1'b1;
    else if (buf_discard)                    bufv_d = 1'b0;
    else if (op_done && op_is_write)         bufv_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      ie_q   <= 1'b0;
      bufv_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      ie_q   <= ie_d;
      bufv_q <= bufv_d;
    end
  end

  assign buf_discard  = csr_ok && (csr_wdata[4:0] == CMD_REEN) && bufv_q;
  assign buf_we       = go_fill;
  assign buf_waddr    = st_z[WB:1];
  assign buf_wdata    = st_data;
  assign ld_hit       = ld_strobe && armed && (cmd_q == CMD_LOCK) && win_early;
  assign ld_data      = ld_hit ? lock_rd : '0;
  assign fl_erase_req = op_active && !op_is_write;
  assign fl_write_req = op_active && op_is_write;
  assign fl_page      = op_page;
  assign rww_busy     = op_busy;
  assign cpu_halt     = op_halt;
  assign irq          = ie_q && gie && !cmd_q[0];
  assign csr_rdata    = {ie_q, op_busy, 1'b0, cmd_q};
endmodule

// File: rtl/flash_selfprog_ctrl_chk.sv
module flash_selfprog_ctrl_chk
  import flash_spm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       csr_we,
  input logic [7:0] csr_wdata,
  input logic [7:0] csr_rdata,
  input logic       st_strobe,
  input logic       buf_we,
  input logic       rww_busy,
  input logic       fl_erase_req,
  input logic       fl_write_req,
  input logic       fl_done,
  input logic       cpu_halt,
  input logic       ld_hit
);
  // R2: illegal code on an idle field leaves it idle
  a_r2_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    csr_we && !cmd_legal(csr_wdata[4:0]) && !st_strobe && !fl_done &&
    (csr_rdata[4:0] == 5'd0) |=> (csr_rdata[4:0] == 5'd0));

  // R4: a fill consumes the command
  a_r4_fill_clears_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> (csr_rdata[4:0] == 5'd0));

  // R5: requests persist until done, with command bits held
  a_r5_erase_held: assert property (@(posedge clk) disable iff (!rst_n)
    fl_erase_req && !fl_done |=> fl_erase_req);
  a_r5_write_cmd_set: assert property (@(posedge clk) disable iff (!rst_n)
    fl_write_req |-> (csr_rdata[2] && csr_rdata[0]));
  a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_erase_req, fl_write_req}));

  // R6: halt only during an operation
  a_r6_halt_in_op: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halt |-> (fl_erase_req || fl_write_req));

  // R7: a fill releases busy
  a_r7_fill_unbusy: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |=> !rww_busy);

  // R11: special load only under lock command
  a_r11_hit_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit |-> (csr_rdata[4:0] == CMD_LOCK));

  // R13: no store effect without enable
  a_r13_unarmed_store: assert property (@(posedge clk) disable iff (!rst_n)
    st_strobe && !csr_rdata[0] |-> !buf_we);
endmodule

bind flash_selfprog_ctrl flash_selfprog_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .st_strobe(st_strobe), .buf_we(buf_we),
  .rww_busy(rww_busy), .fl_erase_req(fl_erase_req), .fl_write_req(fl_write_req),
  .fl_done(fl_done), .cpu_halt(cpu_halt), .ld_hit(ld_hit)
);

// File: tb/flash_selfprog_ctrl_test.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_test;
  localparam int LAT   = 6;
  localparam int BOUND = 96;
  localparam logic [7:0] FUSE = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_we = 1'b0, gie = 1'b0, st_strobe = 1'b0, ld_strobe = 1'b0, ld_z0 = 1'b0;
  logic fl_done = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [15:0] st_z = '0, st_data = '0;
  logic [7:0] csr_rdata, ld_data, lock_bits;
  logic ld_hit, buf_we, buf_discard, fl_erase_req, fl_write_req;
  logic rww_busy, cpu_halt, irq;
  logic [5:0] buf_waddr;
  logic [15:0] buf_wdata;
  logic [8:0] fl_page;

  always #4 clk = ~clk;

  flash_selfprog_ctrl uut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .gie(gie), .st_strobe(st_strobe), .st_z(st_z),
    .st_data(st_data), .ld_strobe(ld_strobe), .ld_z0(ld_z0), .fuse_bits(FUSE),
    .ld_hit(ld_hit), .ld_data(ld_data), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .buf_discard(buf_discard), .fl_erase_req(fl_erase_req),
    .fl_write_req(fl_write_req), .fl_page(fl_page), .fl_done(fl_done),
    .rww_busy(rww_busy), .cpu_halt(cpu_halt), .irq(irq), .lock_bits(lock_bits)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  // reference model state
  int m_cmd = 0, m_win = 0, m_op = 0, m_opcnt = 0, m_page = 0, m_lock = 0;
  bit m_busy = 0, m_ie = 0, m_bufv = 0;

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic chk_regs();
    chk("csr_rdata", int'(csr_rdata), (int'(m_ie) << 7) | (int'(m_busy) << 6) | m_cmd);
    chk("irq", int'(irq), int'(m_ie && gie && !(m_cmd & 1)));
    chk("erase_req", int'(fl_erase_req), int'(m_op == 1));
    chk("write_req", int'(fl_write_req), int'(m_op == 2));
    if (m_op != 0) chk("fl_page", int'(fl_page), m_page);
    chk("cpu_halt", int'(cpu_halt), int'(m_op != 0 && m_page >= BOUND));
    chk("rww_busy", int'(rww_busy), int'(m_busy));
    chk("lock_bits", int'(lock_bits), m_lock);
  endtask

  // one clock cycle: inputs already set at a falling edge
  task automatic cyc();
    bit armed, go, ok, e_we, e_disc, e_hit, done;
    int e_ld, code;
    fl_done = (m_op != 0 && m_opcnt == LAT);
    #1;
    armed  = (m_cmd & 1) && m_win > 0 && m_op == 0;
    go     = st_strobe && armed;
    code   = int'(csr_wdata[4:0]);
    ok     = csr_we && (code inside {1, 3, 5, 9, 17}) && m_op == 0 && !go;
    e_we   = go && m_cmd == 1;
    e_disc = ok && code == 17 && m_bufv;
    e_hit  = ld_strobe && armed && m_cmd == 9 && m_win >= 2;
    e_ld   = e_hit ? (ld_z0 ? int'(FUSE) : m_lock) : 0;
    chk("buf_we", int'(buf_we), int'(e_we));
    if (e_we) begin
      chk("buf_waddr", int'(buf_waddr), (int'(st_z) >> 1) & 63);
      chk("buf_wdata", int'(buf_wdata), int'(st_data));
    end
    chk("buf_discard", int'(buf_discard), int'(e_disc));
    chk("ld_hit", int'(ld_hit), int'(e_hit));
    chk("ld_data", int'(ld_data), e_ld);
    done = (m_op != 0) && fl_done;
    if (m_op != 0) m_opcnt++;
    if (csr_we) m_ie = csr_wdata[7];
    if (done) begin
      if (m_op == 2) m_bufv = 0;
      m_op = 0; m_cmd = 0;
    end else if (ok) begin
      m_cmd = code; m_win = 4;
      if (e_disc) m_bufv = 0;
    end else if (go) begin
      m_win = 0;
      case (m_cmd)
        1: begin m_bufv = 1; m_busy = 0; m_cmd = 0; end
        3, 5: begin
          m_op = (m_cmd == 3) ? 1 : 2;
          m_page = int'(st_z) >> 7;
          m_opcnt = 0;
          if (m_page < BOUND) m_busy = 1;
        end
        9: begin m_lock = int'(st_data) & 8'hFF; m_cmd = 0; end
        default: begin m_busy = 0; m_cmd = 0; end
      endcase
    end else if (m_win > 0) begin
      m_win--;
      if (m_win == 0) m_cmd = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk_regs();
    csr_we = 0; st_strobe = 0; ld_strobe = 0;
  endtask

  task automatic wr(logic [7:0] v);
    csr_we = 1; csr_wdata = v; cyc();
  endtask
  task automatic st(logic [15:0] z, logic [15:0] d);
    st_strobe = 1; st_z = z; st_data = d; cyc();
  endtask
  task automatic ld(logic z0);
    ld_strobe = 1; ld_z0 = z0; cyc();
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk_regs();
    chk("buf_we", int'(buf_we), 0);
    chk("buf_discard", int'(buf_discard), 0);
    idle(2);

    // R2: illegal codes leave the field, ie still written
    cur_req = "R2";
    wr(8'h07); wr(8'h1F); wr(8'h00);
    wr(8'h01); wr(8'h06); wr(8'h83);
    idle(5);

    // R12: irq follows ie, gie and the enable bit
    cur_req = "R12";
    gie = 1; idle(1);
    wr(8'h81); idle(1); idle(4);
    gie = 0; idle(1); gie = 1;

    // R3: window expiry and last-cycle store
    cur_req = "R3";
    wr(8'h81); idle(4); idle(1);
    wr(8'h81); idle(3); st(16'h0010, 16'h1234);

    // R13: unarmed stores and store on the fifth cycle
    cur_req = "R13";
    st(16'h0020, 16'h5555);
    wr(8'h81); idle(4); st(16'h0022, 16'h6666);
    wr(8'h89); idle(4); st(16'h0000, 16'h00EE);

    // R4: fill with address from Z[6:1]
    cur_req = "R4";
    wr(8'h81); st(16'h0046, 16'hBEEF);
    wr(8'h81); idle(1); st(16'h007F, 16'hCAFE);

    // R9: discard only with a filled buffer
    cur_req = "R9";
    wr(8'h91); idle(5);
    wr(8'h91); idle(5);

    // R5 / R6: erase on a read-while-write page sets busy
    cur_req = "R5";
    wr(8'h83); st(16'h0280, 16'hFFFF);
    cur_req = "R8";
    wr(8'h91); wr(8'h85);
    cur_req = "R6";
    idle(LAT + 2);

    // R7: re-enable after completion releases busy
    cur_req = "R7";
    wr(8'h91); st(16'h0000, 16'h0000);

    // R6: non-read-while-write page holds halt
    cur_req = "R6";
    wr(8'h85); st(16'h3200, 16'h0000);
    idle(LAT + 2);

    // R7 / R9: page write on rww page, fill releases busy, write empties buffer
    cur_req = "R7";
    wr(8'h81); st(16'h0002, 16'hAAAA);
    wr(8'h85); st(16'h0300, 16'h0000);
    idle(LAT + 2);
    cur_req = "R9";
    wr(8'h91); idle(5);
    cur_req = "R7";
    wr(8'h83); st(16'h0400, 16'h0000);
    idle(LAT + 2);
    wr(8'h81); st(16'h0004, 16'h0101);

    // R10 / R11: lock write and special loads
    cur_req = "R11";
    wr(8'h89); ld(1'b0); ld(1'b1); ld(1'b0);
    cur_req = "R10";
    st(16'hFFFF, 16'h3C5A);
    cur_req = "R11";
    wr(8'h89); idle(3); ld(1'b1);
    idle(2);
    wr(8'h89); ld(1'b0);
    idle(5);

    finish_run();
  end
endmodule